// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM command bus and runs the start-up ritual the memory needs before any normal access. After reset it keeps clock enable and every data mask high and drives only no-operation commands for a programmable hold time. It then closes all banks with one precharge-all, waits the precharge time, and issues a programmable number of auto-refresh commands, one refresh cycle time apart. It finishes by loading the mode register with a value supplied on an input.

Once the mode-register recovery time has run out, `init_done` rises and the rest of the controller may take over the bus. All timing values are parameters counted in clock cycles. Every bus output comes straight from a flop.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the bus carries NOP, `cke` is 1, every `dqm` bit is 1 and `init_done` is 0. The command field {cs_n, ras_n, cas_n, we_n} is encoded as NOP=0111, PRE=0010, REF=0001 and MRS=0000.
- R2: Until `init_done` rises, `cke` stays 1 and every `dqm` bit stays 1. From the cycle `init_done` is 1, `dqm` is all zeros.
- R3: Exactly WAIT_CYC NOP cycles follow reset. The next cycle carries one PRE with `addr` bit AP_BIT (10) set, all other `addr` bits 0 and `ba` 0.
- R4: The first REF appears exactly TRP_CYC cycles after the PRE, with NOP in between.
- R5: Exactly REF_CNT REF commands are issued, each TRFC_CYC cycles after the one before. REF_CNT must be at least 8.
- R6: MRS appears TRFC_CYC cycles after the last REF, with `addr` equal to `mode_val` and `ba` 0.
- R7: `init_done` rises exactly TMRD_CYC cycles after the MRS and stays 1 until the next reset. From the MRS onward the bus carries only NOP.
- R8: Asserting `rst` at any point restarts the whole sequence from the hold phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_val | input | ADDR_W | Value loaded by the mode register set |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| dqm | output | DQM_W | Data masks |
| init_done | output | 1 | Sequence complete, sticky until reset |

## Verification
The full sequence is run with two different mode values. Matching MRS addresses show that the loaded value comes from the input and is not a constant. Every non-NOP command is timestamped against a table of expected cycles, so a one-cycle error in any of the hold, precharge, refresh or recovery waits shows up as a misplaced event. A reset applied partway through the refreshes, followed by a clean rerun, separates a true restart from a sequencer that resumes where it stopped. A reset after completion confirms that the done flag and masks return to their reset values.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef enum logic [2:0] {
    PH_HOLD, PH_PALL, PH_PWAIT, PH_AREF, PH_RWAIT, PH_MODE, PH_MWAIT, PH_READY
  } phase_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_PALL = 4'b0010;
  localparam logic [3:0] CMD_AREF = 4'b0001;
  localparam logic [3:0] CMD_MODE = 4'b0000;
endpackage

// File: rtl/init_wait_ctr.sv
module init_wait_ctr #(
  parameter int unsigned CW      = 16,
  parameter int unsigned RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= CW'(RST_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/init_bus_drv.sv
module init_bus_drv
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned DQM_W  = 8,
  parameter int unsigned AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            nxt,
  input  logic [ADDR_W-1:0] mode_val,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic [DQM_W-1:0]  dqm,
  output logic              cke,
  output logic              done
);
  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd  <= CMD_NOP;
      addr <= '0;
      ba   <= '0;
      dqm  <= '1;
      cke  <= 1'b1;
      done <= 1'b0;
    end else begin
      cke  <= 1'b1;
      ba   <= '0;
      done <= (nxt == PH_READY);
      dqm  <= (nxt == PH_READY) ? '0 : '1;
      case (nxt)
        PH_PALL: begin cmd <= CMD_PALL; addr <= AP_MASK;  end
        PH_AREF: begin cmd <= CMD_AREF; addr <= '0;       end
        PH_MODE: begin cmd <= CMD_MODE; addr <= mode_val; end
        default: begin cmd <= CMD_NOP;  addr <= '0;       end
      endcase
    end
  end
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 40000,
  parameter int unsigned TRP_CYC  = 3,
  parameter int unsigned REF_CNT  = 8,
  parameter int unsigned TRFC_CYC = 10,
  parameter int unsigned TMRD_CYC = 2,
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned BA_W     = 2,
  parameter int unsigned DQM_W    = 8,
  parameter int unsigned AP_BIT   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mode_val,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic [DQM_W-1:0]  dqm,
  output logic              init_done
);
  localparam int unsigned M1   = (WAIT_CYC > TRP_CYC) ? WAIT_CYC : TRP_CYC;
  localparam int unsigned M2   = (TRFC_CYC > TMRD_CYC) ? TRFC_CYC : TMRD_CYC;
  localparam int unsigned MAXV = (M1 > M2) ? M1 : M2;
  localparam int unsigned CW   = $clog2(MAXV + 1) + 1;
  localparam int unsigned RW   = $clog2(REF_CNT + 1) + 1;

  phase_e        state, nxt;
  logic          ld, t_zero, ref_dec;
  logic [CW-1:0] ld_val;
  logic [RW-1:0] refs_left;
  logic [3:0]    cmd;

  init_wait_ctr #(.CW(CW), .RST_VAL(WAIT_CYC - 1)) u_ctr (
    .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .zero(t_zero)
  );

  always_comb begin
    nxt     = state;
    ld      = 1'b0;
    ld_val  = '0;
    ref_dec = 1'b0;
    case (state)
      PH_HOLD:  if (t_zero) nxt = PH_PALL;
      PH_PALL:  begin nxt = PH_PWAIT; ld = 1'b1; ld_val = CW'(TRP_CYC - 2);  end
      PH_PWAIT: if (t_zero) nxt = PH_AREF;
      PH_AREF:  begin nxt = PH_RWAIT; ld = 1'b1; ld_val = CW'(TRFC_CYC - 2); ref_dec = 1'b1; end
      PH_RWAIT: if (t_zero) nxt = (refs_left == '0) ? PH_MODE : PH_AREF;
      PH_MODE:  begin nxt = PH_MWAIT; ld = 1'b1; ld_val = CW'(TMRD_CYC - 2); end
      PH_MWAIT: if (t_zero) nxt = PH_READY;
      default:  nxt = PH_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PH_HOLD;
      refs_left <= RW'(REF_CNT);
    end else begin
      state <= nxt;
      if (ref_dec) refs_left <= refs_left - 1'b1;
    end
  end

  init_bus_drv #(.ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W), .AP_BIT(AP_BIT)) u_drv (
    .clk(clk), .rst(rst), .nxt(nxt), .mode_val(mode_val),
    .cmd(cmd), .addr(addr), .ba(ba), .dqm(dqm), .cke(cke), .done(init_done)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;

  // Checker state observed from the bus outputs
  logic [CW-1:0] nop_run;
  logic [RW-1:0] refs_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      nop_run   <= '0;
      refs_seen <= '0;
    end else begin
      if (cmd != CMD_NOP)  nop_run <= '0;
      else if (nop_run != '1) nop_run <= nop_run + 1'b1;
      if (cmd == CMD_AREF && refs_seen != '1) refs_seen <= refs_seen + 1'b1;
    end
  end

  p_masks_until_done_r2: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> (cke && (&dqm)));
  p_hold_then_pall_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PALL) |-> (nop_run == CW'(WAIT_CYC) && addr[AP_BIT] && ba == '0));
  p_first_ref_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_AREF && refs_seen == '0) |-> nop_run == CW'(TRP_CYC - 1));
  p_ref_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_AREF && refs_seen != '0) |-> nop_run == CW'(TRFC_CYC - 1));
  p_min_refs_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_MODE) |-> (refs_seen >= RW'(8) && refs_seen == RW'(REF_CNT)));
  p_mode_value_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_MODE) |-> (addr == mode_val && nop_run == CW'(TRFC_CYC - 1)));
  p_done_delay_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> nop_run == CW'(TMRD_CYC - 1));
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cmd == CMD_NOP));
endmodule

// File: tb/sdram_pwrup_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_pwrup_seq_tb_top;
  localparam int W = 20, TRP = 3, NREF = 8, TRFC = 5, TMRD = 2;
  localparam int NEV = NREF + 2;
  localparam int DONE_AT = W + TRP + NREF * TRFC + TMRD;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  // Expected command events: {cycle after reset release, command}
  localparam int         EXP_CYC [NEV] = '{20, 23, 28, 33, 38, 43, 48, 53, 58, 63};
  localparam logic [3:0] EXP_CMD [NEV] = '{PRE, REF, REF, REF, REF, REF, REF, REF, REF, MRS};

  logic clk = 0, rst = 1;
  logic [12:0] mode_val = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [12:0] addr;
  logic [7:0] dqm;

  always #2.5 clk = ~clk;

  sdram_pwrup_seq #(.WAIT_CYC(W), .TRP_CYC(TRP), .REF_CNT(NREF), .TRFC_CYC(TRFC),
                    .TMRD_CYC(TMRD)) dut_i (
    .clk(clk), .rst(rst), .mode_val(mode_val), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm), .init_done(init_done)
  );

  int n_run = 0, n_fail = 0;
  int ev_n, done_cyc, mask_bad, done_drop, busy_after;
  int ev_cyc [16];
  logic [3:0] ev_cmd [16];
  logic [12:0] ev_addr [16];
  logic [1:0] ev_ba [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == NOP, "R1", "cmd in reset", {cs_n, ras_n, cas_n, we_n}, NOP);
    chk(cke && dqm == 8'hFF && !init_done, "R1", "cke/dqm/done in reset",
        {cke, dqm, init_done}, {1'b1, 8'hFF, 1'b0});
    rst = 0;
  endtask

  task automatic trace(input int ncyc);
    ev_n = 0; done_cyc = -1; mask_bad = 0; done_drop = 0; busy_after = 0;
    for (int c = 0; c < ncyc; c++) begin
      if (!init_done && !(cke && dqm == 8'hFF)) mask_bad++;
      if (init_done && dqm != 8'h00) mask_bad++;
      if (init_done && done_cyc < 0) done_cyc = c;
      if (!init_done && done_cyc >= 0) done_drop++;
      if ({cs_n, ras_n, cas_n, we_n} != NOP) begin
        if (ev_n > 0 && ev_cmd[ev_n-1] == MRS) busy_after++;
        if (ev_n < 16) begin
          ev_cyc[ev_n] = c; ev_cmd[ev_n] = {cs_n, ras_n, cas_n, we_n};
          ev_addr[ev_n] = addr; ev_ba[ev_n] = ba;
        end
        ev_n++;
      end
      @(negedge clk);
    end
  endtask

  task automatic full_check(input logic [12:0] mv, input string tag);
    mode_val = mv;
    do_reset();
    trace(DONE_AT + 40);
    chk(ev_n == NEV, "R5", {tag, " command count"}, ev_n, NEV);
    for (int i = 0; i < NEV; i++) begin
      string rq;
      rq = (i == 0) ? "R3" : (i == 1) ? "R4" : (i == NEV - 1) ? "R6" : "R5";
      chk(ev_cyc[i] == EXP_CYC[i] && ev_cmd[i] == EXP_CMD[i], rq,
          $sformatf("%s event %0d cycle", tag, i), ev_cyc[i], EXP_CYC[i]);
    end
    chk(ev_addr[0] == 13'h0400 && ev_ba[0] == 0, "R3", {tag, " PRE addr"}, ev_addr[0], 13'h0400);
    chk(ev_addr[NEV-1] == mv && ev_ba[NEV-1] == 0, "R6", {tag, " MRS addr"}, ev_addr[NEV-1], mv);
    chk(done_cyc == DONE_AT, "R7", {tag, " done cycle"}, done_cyc, DONE_AT);
    chk(done_drop == 0 && busy_after == 0, "R7", {tag, " done sticky/quiet"},
        done_drop + busy_after, 0);
    chk(mask_bad == 0, "R2", {tag, " cke/dqm"}, mask_bad, 0);
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "WD", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    full_check(13'h0033, "modeA");
    full_check(13'h1A5C, "modeB");
    // R8: reset in the middle of the refresh phase, then a clean rerun
    mode_val = 13'h0027;
    do_reset();
    trace(40);
    chk(ev_n > 2 && ev_cyc[0] == W, "R8", "pre-abort PRE cycle", ev_cyc[0], W);
    full_check(13'h0027, "restart");
    // R1: reset after completion clears done
    do_reset();
    chk(!init_done, "R1", "done after post-done reset", init_done, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule